// File: doc/BRIEF.md
# Line Condition Status and Interrupt Register

This block sits between a line interface and its host. It watches three condition inputs coming from the line side: loss of signal, alarm indication and network loopback. Each input is synchronized to the block clock. Any change of level on an input, in either direction, sets a sticky change flag. While any flag is set, the active-low interrupt output is held low. The host clears a flag by writing 1 to the matching control bit. As long as that bit stays 1, the source is also masked. Writing 0 to the bit re-enables the source.

The same byte-wide register holds three loop and test controls: far-end loopback, local loopback and all-ones transmit. A read returns these controls together with the three mask bits and a 3-bit status code. The code reports the change flags and the loop state in a fixed order of precedence. A write that sets both loopback bits at once does not load the register; it acts as a soft reset instead. It zeroes every register bit, clears the change flags and issues one-cycle pulses that drop network loopback and request recalibration. When the line is configured for short haul, a soft reset also leaves the loss-of-signal flag set.

Top module: `line_alarm_irq_reg`

## Requirements
- R1: After rst_n is released, irq_n is 1, a read returns 0x00, and rloop_on, lloop_on, ones_tx_on, recal_req and netloop_drop are all 0.
- R2: While its mask bit is 0, a level change on loss_in, alarm_in or netloop_in sets a sticky flag. The bench drives the change just before clock edge E1. irq_n is still 1 after edge E2 and goes low after edge E3.
- R3: A read (rd_en) returns the register state on rd_data after the next clock edge. A read leaves every flag and irq_n unchanged.
- R4: Writing 1 to a mask bit clears that flag at the write's clock edge, so irq_n rises right after that edge once no flag remains. While the bit stays 1, further changes on that input are ignored. The mask bits in wr_data are: [3] loss, [4] netloop, [5] alarm.
- R5: Writing 0 to a mask bit re-enables its source. Changes after that set the flag again.
- R6: rd_data layout: [0] far-end loopback, [1] local loopback, [2] all-ones transmit, [3] loss mask, [4] netloop mask, [7:5] status code. The alarm mask is write-only. Status code values: 000 idle, 001 far-end loopback, 010 local loopback, 011 loss changed, 100 all-ones transmit, 101 netloop changed, 110 all-ones transmit with local loopback, 111 both loss and netloop changed. The alarm flag raises the interrupt but has no code.
- R7: The code is chosen in this order of precedence: both changes, netloop change, loss change, all-ones with local loopback, all-ones transmit, local loopback, far-end loopback, idle.
- R8: A write with wr_data[1:0]=11 is a soft reset. After that edge, all control and mask bits and all flags are 0. recal_req and netloop_drop are each 1 for exactly that one cycle.
- R9: If short_haul is 1 during a soft reset, the loss flag is left set. After that edge, irq_n is 0 and the code reads 011.
- R10: A write without the soft-reset pattern loads wr_data[5:0] into the control bits. rloop_on, lloop_on and ones_tx_on follow bits [0], [1] and [2] right after the write's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| short_haul | input | 1 | Short-haul configuration strap |
| loss_in | input | 1 | Loss-of-signal condition, asynchronous |
| alarm_in | input | 1 | Alarm-indication condition, asynchronous |
| netloop_in | input | 1 | Network-loopback condition, asynchronous |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt |
| rloop_on | output | 1 | Far-end loopback enable |
| lloop_on | output | 1 | Local loopback enable |
| ones_tx_on | output | 1 | All-ones transmit enable |
| netloop_drop | output | 1 | One-cycle pulse that drops network loopback |
| recal_req | output | 1 | One-cycle recalibration request |

## Verification
Each result has a fixed latency:
- Control outputs, flag clears and soft-reset pulses appear one edge after the write is captured.
- Read data appears one edge after rd_en.
- An input change reaches irq_n on the third edge: two synchronizer stages and the previous-value register.

The bench drives every stimulus on a falling edge and samples on a later falling edge, counted to match these latencies. For input changes it checks irq_n both one edge early, when it must still be high, and on the due edge.

// File: rtl/lsi_pkg.sv
package lsi_pkg;

  localparam int NCOND   = 3;
  localparam int IDX_LOS = 0;
  localparam int IDX_AIS = 1;
  localparam int IDX_NL  = 2;
  localparam int DW      = 8;

  // write-field bit positions
  localparam int B_RLOOP = 0;
  localparam int B_LLOOP = 1;
  localparam int B_ONES  = 2;
  localparam int B_MLOS  = 3;
  localparam int B_MNL   = 4;
  localparam int B_MAIS  = 5;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RLOOP   = 3'd1,
    ST_LLOOP   = 3'd2,
    ST_LOSCHG  = 3'd3,
    ST_ONES    = 3'd4,
    ST_NLCHG   = 3'd5,
    ST_ONES_LL = 3'd6,
    ST_BOTHCHG = 3'd7
  } stat_code_e;

  typedef struct packed {
    logic mask_ais;
    logic mask_nl;
    logic mask_los;
    logic ones;
    logic lloop;
    logic rloop;
  } ctl_t;

endpackage

// File: rtl/lsi_chg_detect.sv
module lsi_chg_detect #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] chg
);

  localparam int LAST = STAGES - 1;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_ch
      logic [STAGES-1:0] sh_q;
      logic [STAGES-1:0] sh_d;
      logic              prev_q;

      always_comb begin
        sh_d = {sh_q[STAGES-2:0], raw[gi]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sh_q   <= '0;
          prev_q <= 1'b0;
        end else begin
          sh_q   <= sh_d;
          prev_q <= sh_q[LAST];
        end
      end

      assign chg[gi] = sh_q[LAST] ^ prev_q;
    end
  endgenerate

endmodule

// File: rtl/lsi_ctl_bank.sv
module lsi_ctl_bank
  import lsi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output ctl_t          ctl_q,
  output ctl_t          ctl_d,
  output logic          soft_rst,
  output logic          recal_q,
  output logic          nldrop_q
);

  logic load_en;

  always_comb begin
    soft_rst = wr_en & wr_data[B_RLOOP] & wr_data[B_LLOOP];
    load_en  = wr_en & ~soft_rst;
    ctl_d    = ctl_q;
    if (soft_rst) begin
      ctl_d = '0;
    end else if (load_en) begin
      ctl_d.rloop    = wr_data[B_RLOOP];
      ctl_d.lloop    = wr_data[B_LLOOP];
      ctl_d.ones     = wr_data[B_ONES];
      ctl_d.mask_los = wr_data[B_MLOS];
      ctl_d.mask_nl  = wr_data[B_MNL];
      ctl_d.mask_ais = wr_data[B_MAIS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      recal_q  <= 1'b0;
      nldrop_q <= 1'b0;
    end else begin
      ctl_q    <= ctl_d;
      recal_q  <= soft_rst;
      nldrop_q <= soft_rst;
    end
  end

endmodule

// File: rtl/lsi_sticky.sv
module lsi_sticky
  import lsi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCOND-1:0] chg,
  input  logic [NCOND-1:0] mask_nxt,
  input  logic             soft_rst,
  input  logic             short_haul,
  output logic [NCOND-1:0] flag_q
);

  logic [NCOND-1:0] flag_d;

  always_comb begin
    flag_d = flag_q;
    if (soft_rst) begin
      flag_d          = '0;
      flag_d[IDX_LOS] = short_haul;
    end else begin
      for (int i = 0; i < NCOND; i++) begin
        if (mask_nxt[i]) flag_d[i] = 1'b0;
        else if (chg[i]) flag_d[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/lsi_code_enc.sv
module lsi_code_enc
  import lsi_pkg::*;
(
  input  logic       los_f,
  input  logic       nl_f,
  input  logic       ones,
  input  logic       lloop,
  input  logic       rloop,
  output stat_code_e code
);

  always_comb begin
    if (los_f && nl_f)      code = ST_BOTHCHG;
    else if (nl_f)          code = ST_NLCHG;
    else if (los_f)         code = ST_LOSCHG;
    else if (ones && lloop) code = ST_ONES_LL;
    else if (ones)          code = ST_ONES;
    else if (lloop)         code = ST_LLOOP;
    else if (rloop)         code = ST_RLOOP;
    else                    code = ST_IDLE;
  end

endmodule

// File: rtl/line_alarm_irq_reg.sv
module line_alarm_irq_reg
  import lsi_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       short_haul,
  input  logic       loss_in,
  input  logic       alarm_in,
  input  logic       netloop_in,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       irq_n,
  output logic       rloop_on,
  output logic       lloop_on,
  output logic       ones_tx_on,
  output logic       netloop_drop,
  output logic       recal_req
);

  // reset: asserted asynchronously, released through a flop chain
  logic [RST_STAGES-1:0] rs_q;
  logic                  irst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[RST_STAGES-2:0], 1'b1};
  end
  assign irst_n = rs_q[RST_STAGES-1];

  logic [NCOND-1:0] raw, chg, flags, mask_nxt;
  ctl_t             ctl_q, ctl_d;
  logic             soft_rst;
  stat_code_e       code;
  logic [DW-1:0]    rd_q, rd_d;

  always_comb begin
    raw          = '0;
    raw[IDX_LOS] = loss_in;
    raw[IDX_AIS] = alarm_in;
    raw[IDX_NL]  = netloop_in;
    mask_nxt          = '0;
    mask_nxt[IDX_LOS] = ctl_d.mask_los;
    mask_nxt[IDX_AIS] = ctl_d.mask_ais;
    mask_nxt[IDX_NL]  = ctl_d.mask_nl;
  end

  lsi_chg_detect #(.N(NCOND), .STAGES(SYNC_STAGES)) u_det (
    .clk(clk), .rst_n(irst_n), .raw(raw), .chg(chg)
  );

  lsi_ctl_bank u_ctl (
    .clk(clk), .rst_n(irst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ctl_q(ctl_q), .ctl_d(ctl_d), .soft_rst(soft_rst),
    .recal_q(recal_req), .nldrop_q(netloop_drop)
  );

  lsi_sticky u_stk (
    .clk(clk), .rst_n(irst_n), .chg(chg), .mask_nxt(mask_nxt),
    .soft_rst(soft_rst), .short_haul(short_haul), .flag_q(flags)
  );

  lsi_code_enc u_enc (
    .los_f(flags[IDX_LOS]), .nl_f(flags[IDX_NL]), .ones(ctl_q.ones),
    .lloop(ctl_q.lloop), .rloop(ctl_q.rloop), .code(code)
  );

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = {code, ctl_q.mask_nl, ctl_q.mask_los, ctl_q.ones,
              ctl_q.lloop, ctl_q.rloop};
    end
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) rd_q <= '0;
    else         rd_q <= rd_d;
  end

  assign rd_data    = rd_q;
  assign irq_n      = ~|flags;
  assign rloop_on   = ctl_q.rloop;
  assign lloop_on   = ctl_q.lloop;
  assign ones_tx_on = ctl_q.ones;

endmodule

// File: rtl/lsi_checker.sv
module lsi_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       irq_n,
  input logic       rloop_on,
  input logic       lloop_on,
  input logic       ones_tx_on,
  input logic       recal_req,
  input logic       netloop_drop
);

  logic is_srst;
  assign is_srst = wr_en && wr_data[0] && wr_data[1];

  a_r8_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
    is_srst |=> (!rloop_on && !lloop_on && !ones_tx_on && recal_req && netloop_drop));

  a_r8_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |-> $past(is_srst));

  a_r10_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_srst) |=> (rloop_on == $past(wr_data[0]) &&
                             lloop_on == $past(wr_data[1]) &&
                             ones_tx_on == $past(wr_data[2])));

  a_r4_all_masked_release: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !is_srst && wr_data[5:3] == 3'b111) |=> irq_n);

  a_r3_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !wr_en) |=> !irq_n);

endmodule

bind line_alarm_irq_reg lsi_checker u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .irq_n(irq_n), .rloop_on(rloop_on), .lloop_on(lloop_on),
  .ones_tx_on(ones_tx_on), .recal_req(recal_req), .netloop_drop(netloop_drop)
);

// File: tb/tb_line_alarm_irq_reg.sv
`timescale 1ns/1ps
module tb_line_alarm_irq_reg;

  logic       clk = 1'b0;
  logic       rst_n, short_haul, loss_in, alarm_in, netloop_in;
  logic       wr_en, rd_en;
  logic [7:0] wr_data, rd_data;
  logic       irq_n, rloop_on, lloop_on, ones_tx_on, netloop_drop, recal_req;
  int         total = 0;
  int         bad   = 0;
  logic       done  = 1'b0;

  always #4 clk = ~clk;

  line_alarm_irq_reg dut (
    .clk(clk), .rst_n(rst_n), .short_haul(short_haul), .loss_in(loss_in),
    .alarm_in(alarm_in), .netloop_in(netloop_in), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n),
    .rloop_on(rloop_on), .lloop_on(lloop_on), .ones_tx_on(ones_tx_on),
    .netloop_drop(netloop_drop), .recal_req(recal_req)
  );

  // {write value, expected read-back}
  localparam logic [15:0] VEC [8] = '{
    16'h0121, 16'h0242, 16'h0484, 16'h06C6,
    16'h0585, 16'h0C8C, 16'h1818, 16'h0000
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic host_rd(output logic [7:0] v);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0x1 expected=0x0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; short_haul = 1'b0; loss_in = 1'b0; alarm_in = 1'b0;
    netloop_in = 1'b0; wr_en = 1'b0; wr_data = 8'h00; rd_en = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);

    // R1 reset state
    chk("R1 irq_n", irq_n, 1);
    chk("R1 outputs", {rloop_on, lloop_on, ones_tx_on, recal_req, netloop_drop}, 0);
    host_rd(r);
    chk("R1 read", r, 8'h00);

    // R10 / R6 table of control patterns
    for (int k = 0; k < 8; k++) begin
      host_wr(VEC[k][15:8]);
      chk("R10 outputs", {ones_tx_on, lloop_on, rloop_on}, VEC[k][10:8]);
      host_rd(r);
      chk("R6 code/readback", r, VEC[k][7:0]);
    end

    // R2 loss change latency
    loss_in = 1'b1;
    wait_n(2);
    chk("R2 irq early", irq_n, 1);
    wait_n(1);
    chk("R2 irq due", irq_n, 0);
    host_rd(r);
    chk("R6 loss code", r, 8'h60);
    host_rd(r);
    chk("R3 reread", r, 8'h60);
    chk("R3 irq held", irq_n, 0);

    // R4 mask clears and ignores
    host_wr(8'h08);
    chk("R4 release", irq_n, 1);
    host_rd(r);
    chk("R4 read", r, 8'h08);
    loss_in = 1'b0;
    wait_n(5);
    chk("R4 ignored", irq_n, 1);

    // R5 re-enable
    host_wr(8'h00);
    chk("R5 no stale", irq_n, 1);
    loss_in = 1'b1;
    wait_n(3);
    chk("R5 rearmed", irq_n, 0);

    // R7 precedence
    host_wr(8'h06);
    host_rd(r);
    chk("R7 loss over ones+ll", r, 8'h66);
    netloop_in = 1'b1;
    wait_n(3);
    host_rd(r);
    chk("R7 both", r, 8'hE6);
    host_wr(8'h0E);
    host_rd(r);
    chk("R7 netloop", r, 8'hAE);
    chk("R4 netloop pending", irq_n, 0);
    host_wr(8'h1E);
    host_rd(r);
    chk("R7 ones+ll", r, 8'hDE);
    chk("R4 all clear", irq_n, 1);

    // R2 alarm has irq but no code
    host_wr(8'h00);
    alarm_in = 1'b1;
    wait_n(3);
    chk("R2 alarm irq", irq_n, 0);
    host_rd(r);
    chk("R6 alarm no code", r, 8'h00);
    host_wr(8'h20);
    chk("R4 alarm clear", irq_n, 1);

    // R8 soft reset
    host_wr(8'h3C);
    wr_en = 1'b1; wr_data = 8'h03;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
    chk("R8 pulses", {recal_req, netloop_drop}, 2'b11);
    chk("R8 controls", {rloop_on, lloop_on, ones_tx_on}, 0);
    @(negedge clk);
    chk("R8 pulse width", {recal_req, netloop_drop}, 0);
    host_rd(r);
    chk("R8 cleared", r, 8'h00);
    chk("R8 irq", irq_n, 1);

    // R9 short haul
    short_haul = 1'b1;
    host_wr(8'h03);
    chk("R9 irq", irq_n, 0);
    host_rd(r);
    chk("R9 code", r, 8'h60);
    short_haul = 1'b0;
    host_wr(8'h08);
    chk("R9 cleared", irq_n, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule